// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block sequences a raster display. It produces horizontal sync, vertical sync and data-enable strobes, together with the column and row of the active pixel. Every interval of a line and of a frame is set through a small register bus. The bus uses one write strobe and one read strobe. Clock generation and pixel fetch happen elsewhere. The pixel path takes `x_o`, `y_o`, `de_o` and `data_inv_o` from this block.

Each line has four phases in a fixed order: sync, back porch, active, then front porch. The frame uses the same four phases, counted in whole lines, and the row counter advances on the last pixel of each line. A polarity register sets the active level of each strobe. A control bit starts and stops scanning. A vertical-sync event sets a sticky status bit, and that bit drives an interrupt line through an enable bit. Interval registers can be rewritten while the block scans. The new values are held back and take effect only at the next frame boundary, so a frame never has a mixed geometry.

Top module: `vtg_top`

## Requirements
- R1: Each interval register holds the interval length minus one. A value of N gives an interval of N+1 pixel clocks horizontally, or N+1 lines vertically. The horizontal registers are sync at address 4, back porch at 5, active at 6 and front porch at 7. The vertical registers are sync at 8, back porch at 9, active at 10 and front porch at 11.
- R2: A line runs through sync, back porch, active and front porch in that order. It lasts the sum of the four horizontal lengths, and then the next line begins in sync.
- R3: The row counter advances on the last pixel of each line. A frame runs through vertical sync, back porch, active and front porch lines in that order, and then wraps to vertical sync.
- R4: Data enable is at its active level exactly when both counters are in their active phase. At that time `x_o` and `y_o` give the zero-based column and row inside the active area. At all other times both are zero.
- R5: The polarity register is at address 3. Bit 0 sets hsync, bit 1 sets vsync and bit 2 sets data enable; a 1 makes that output active high and a 0 makes it active low. Bit 3 appears directly on `data_inv_o`. The reset value is 0.
- R6: Writing 1 to bit 0 of the control register (address 0) starts scanning, and writing 0 stops it. While stopped, both counters are at zero, `x_o` and `y_o` are 0, and every strobe sits at its inactive level. After a start, the first frame cycle is the cycle that follows the write. That cycle is the first pixel of hsync and of vsync.
- R7: The status bit (bit 0 of address 2) is set on the first pixel of each frame and becomes visible one cycle later. It stays set until it is cleared.
- R8: `irq_o` is high exactly when the status bit is set and the enable bit (bit 0 of address 1) is 1.
- R9: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. When a clear and a set fall in the same cycle, the set wins.
- R10: Interval writes made while scanning leave the current frame unchanged. They take effect from the next frame start. While stopped, the latest written values are used at start.
- R11: A read strobe returns the addressed register on `rdata_o` in the following cycle. Interval and polarity registers read back as written, and control, enable and status read back in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after rd_en_i |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| data_inv_o | output | 1 | Data polarity for the pixel path |
| x_o | output | CNT_W | Active column |
| y_o | output | CNT_W | Active row |
| irq_o | output | 1 | Vertical-sync interrupt |

## Verification
Two functions can fall in the same cycle: the status set at a frame start, and a software write-one-to-clear of that same bit. The bench forces the collision by placing the clear write in the first frame cycle right after a start command. It then expects `irq_o` to stay high, and it confirms that a later clear outside that cycle takes effect. A second overlap is an interval write during a frame, which must reach the scanout only at the next frame. A cycle-accurate scoreboard spans both frames to judge it.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam int unsigned NPH = 4;
  localparam int unsigned POL_W = 4;

  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_IRQ_EN = 1;
  localparam int unsigned ADDR_IRQ_ST = 2;
  localparam int unsigned ADDR_POL    = 3;
  localparam int unsigned ADDR_H0     = 4;
  localparam int unsigned ADDR_V0     = 8;

  localparam int unsigned POL_HS   = 0;
  localparam int unsigned POL_VS   = 1;
  localparam int unsigned POL_DE   = 2;
  localparam int unsigned POL_DATA = 3;

endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      run_i,
  input  logic                      step_i,
  input  logic [NPH-1:0][CNT_W-1:0] len_i,
  output phase_e                    phase_o,
  output logic [CNT_W-1:0]          cnt_o,
  output logic                      wrap_o
);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               last;
  logic [1:0]         phase_nxt;

  assign last      = (cnt_q == len_i[phase_q]);
  assign phase_nxt = phase_q + 2'd1;
  assign wrap_o    = run_i & step_i & last & (phase_q == PH_FRONT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (!run_i) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (step_i) begin
      if (last) begin
        phase_q <= phase_e'(phase_nxt);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic                      frame_end_i,
  input  logic                      vs_start_i,
  output logic [DW-1:0]             rdata_o,
  output logic                      run_o,
  output logic [POL_W-1:0]          pol_o,
  output logic                      irq_en_o,
  output logic                      irq_stat_o,
  output logic [NPH-1:0][CNT_W-1:0] h_len_o,
  output logic [NPH-1:0][CNT_W-1:0] v_len_o
);

  localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] A_IEN  = AW'(ADDR_IRQ_EN);
  localparam logic [AW-1:0] A_IST  = AW'(ADDR_IRQ_ST);
  localparam logic [AW-1:0] A_POL  = AW'(ADDR_POL);

  logic                      run_q, ien_q, ist_q;
  logic [POL_W-1:0]          pol_q;
  logic [NPH-1:0][CNT_W-1:0] h_live, v_live, h_sh, v_sh;
  logic [DW-1:0]             rd_mux, rdata_q;
  logic                      ist_clr;
  logic                      unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ien_q  <= 1'b0;
      pol_q  <= '0;
      h_live <= '0;
      v_live <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) run_q <= wdata_i[0];
      if (addr_i == A_IEN)  ien_q <= wdata_i[0];
      if (addr_i == A_POL)  pol_q <= wdata_i[POL_W-1:0];
      for (int p = 0; p < NPH; p++) begin
        if (addr_i == AW'(ADDR_H0 + p)) h_live[p] <= wdata_i[CNT_W-1:0];
        if (addr_i == AW'(ADDR_V0 + p)) v_live[p] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  // set has priority over a same-cycle clear
  assign ist_clr = wr_en_i & (addr_i == A_IST) & wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ist_q <= 1'b0;
    else if (vs_start_i) ist_q <= 1'b1;
    else if (ist_clr)    ist_q <= 1'b0;
  end

  // geometry seen by the counters changes only between frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_sh <= '0;
      v_sh <= '0;
    end else if (!run_q || frame_end_i) begin
      h_sh <= h_live;
      v_sh <= v_live;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_CTRL) rd_mux[0] = run_q;
    if (addr_i == A_IEN)  rd_mux[0] = ien_q;
    if (addr_i == A_IST)  rd_mux[0] = ist_q;
    if (addr_i == A_POL)  rd_mux[POL_W-1:0] = pol_q;
    for (int p = 0; p < NPH; p++) begin
      if (addr_i == AW'(ADDR_H0 + p)) rd_mux[CNT_W-1:0] = h_live[p];
      if (addr_i == AW'(ADDR_V0 + p)) rd_mux[CNT_W-1:0] = v_live[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o    = rdata_q;
  assign run_o      = run_q;
  assign pol_o      = pol_q;
  assign irq_en_o   = ien_q;
  assign irq_stat_o = ist_q;
  assign h_len_o    = h_sh;
  assign v_len_o    = v_sh;

endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             data_inv_o,
  output logic [CNT_W-1:0] x_o,
  output logic [CNT_W-1:0] y_o,
  output logic             irq_o
);

  logic                      run, irq_en, irq_stat;
  logic [POL_W-1:0]          pol;
  logic [NPH-1:0][CNT_W-1:0] h_len, v_len;
  phase_e                    h_phase, v_phase;
  logic [CNT_W-1:0]          h_cnt, v_cnt;
  logic                      h_wrap, frame_end, vs_start;
  logic                      hs_act, vs_act, de_act;

  vtg_regs #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .frame_end_i (frame_end),
    .vs_start_i  (vs_start),
    .rdata_o     (rdata_o),
    .run_o       (run),
    .pol_o       (pol),
    .irq_en_o    (irq_en),
    .irq_stat_o  (irq_stat),
    .h_len_o     (h_len),
    .v_len_o     (v_len)
  );

  vtg_axis #(.CNT_W(CNT_W)) u_h (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .step_i  (1'b1),
    .len_i   (h_len),
    .phase_o (h_phase),
    .cnt_o   (h_cnt),
    .wrap_o  (h_wrap)
  );

  vtg_axis #(.CNT_W(CNT_W)) u_v (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .step_i  (h_wrap),
    .len_i   (v_len),
    .phase_o (v_phase),
    .cnt_o   (v_cnt),
    .wrap_o  (frame_end)
  );

  assign vs_start = run & (h_phase == PH_SYNC) & (h_cnt == '0)
                        & (v_phase == PH_SYNC) & (v_cnt == '0);

  assign hs_act = run & (h_phase == PH_SYNC);
  assign vs_act = run & (v_phase == PH_SYNC);
  assign de_act = run & (h_phase == PH_ACT) & (v_phase == PH_ACT);

  assign hsync_o    = ~(hs_act ^ pol[POL_HS]);
  assign vsync_o    = ~(vs_act ^ pol[POL_VS]);
  assign de_o       = ~(de_act ^ pol[POL_DE]);
  assign data_inv_o = pol[POL_DATA];
  assign x_o        = de_act ? h_cnt : '0;
  assign y_o        = de_act ? v_cnt : '0;
  assign irq_o      = irq_stat & irq_en;

endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
  import vtg_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned CNT_W = 12
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic [AW-1:0]             addr_i,
  input logic                      w0_i,
  input logic                      run_i,
  input logic [POL_W-1:0]          pol_i,
  input logic [1:0]                h_phase_i,
  input logic                      irq_en_i,
  input logic                      irq_stat_i,
  input logic                      vs_start_i,
  input logic                      frame_end_i,
  input logic [NPH-1:0][CNT_W-1:0] h_len_i,
  input logic [NPH-1:0][CNT_W-1:0] v_len_i,
  input logic                      hsync_i,
  input logic                      vsync_i,
  input logic                      de_i,
  input logic [CNT_W-1:0]          x_i,
  input logic [CNT_W-1:0]          y_i,
  input logic                      irq_i
);

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (hsync_i == ~pol_i[POL_HS]) && (vsync_i == ~pol_i[POL_VS])
               && (de_i == ~pol_i[POL_DE]) && (x_i == '0) && (y_i == '0)); // R6

  AST_PHASE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (h_phase_i != $past(h_phase_i)))
      |-> (h_phase_i == 2'($past(h_phase_i) + 2'd1))); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_i); // R8

  AST_STAT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_start_i |=> irq_stat_i); // R7

  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(ADDR_IRQ_ST) && w0_i && !vs_start_i) |=> !irq_stat_i); // R9

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(frame_end_i))
      |-> ($stable(h_len_i) && $stable(v_len_i))); // R10

endmodule

bind vtg_top vtg_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .w0_i        (wdata_i[0]),
  .run_i       (run),
  .pol_i       (pol),
  .h_phase_i   (h_phase),
  .irq_en_i    (irq_en),
  .irq_stat_i  (irq_stat),
  .vs_start_i  (vs_start),
  .frame_end_i (frame_end),
  .h_len_i     (h_len),
  .v_len_i     (v_len),
  .hsync_i     (hsync_o),
  .vsync_i     (vsync_o),
  .de_i        (de_o),
  .x_i         (x_o),
  .y_i         (y_o),
  .irq_i       (irq_o)
);

// File: tb/tb_vtg_top.sv
`timescale 1ns/1ps
module tb_vtg_top;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          hsync, vsync, de, dinv, irq;
  logic [CW-1:0] x, y;

  always #2.5 clk = ~clk;

  vtg_top #(.AW(AW), .DW(DW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .data_inv_o(dinv),
    .x_o(x), .y_o(y), .irq_o(irq)
  );

  typedef struct packed {
    logic          hs, vs, de;
    logic [CW-1:0] x, y;
    logic          irq;
  } smp_t;

  smp_t exp_q[$];
  bit   mon_on = 1'b0;
  int   n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // driver side of the scoreboard: expected per-cycle items of one frame
  task automatic push_frame(input int hs, hb, ha, hf, vs, vb, va, vf,
                            input logic [3:0] pol, input bit irq0);
    int ht = hs + hb + ha + hf;
    int vt = vs + vb + va + vf;
    for (int t = 0; t < ht * vt; t++) begin
      int  px = t % ht;
      int  ln = t / ht;
      bit  h_s = px < hs;
      bit  v_s = ln < vs;
      bit  h_a = (px >= hs + hb) && (px < hs + hb + ha);
      bit  v_a = (ln >= vs + vb) && (ln < vs + vb + va);
      smp_t s;
      s.hs  = pol[0] ? h_s : !h_s;
      s.vs  = pol[1] ? v_s : !v_s;
      s.de  = pol[2] ? (h_a && v_a) : !(h_a && v_a);
      s.x   = (h_a && v_a) ? CW'(px - hs - hb) : '0;
      s.y   = (h_a && v_a) ? CW'(ln - vs - vb) : '0;
      s.irq = (t == 0) ? irq0 : 1'b1;
      exp_q.push_back(s);
    end
  endtask

  task automatic start_mon();
    @(negedge clk);
    wr_en = 1'b1; addr = 0; wdata = 1;
    @(posedge clk);
    mon_on = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      smp_t e;
      e = exp_q.pop_front();
      chk("R1 R2 R3 R4 R5 timing", {hsync, vsync, de, x, y},
          {e.hs, e.vs, e.de, e.x, e.y});
      chk("R7 irq", irq, e.irq);
      if (exp_q.size() == 0) mon_on = 1'b0;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: polarity 0 means active low, so idle is high
    chk("R6 reset strobes", {hsync, vsync, de, x, y}, {3'b111, 24'd0});
    chk("R8 reset irq", irq, 1'b0);
    rd(0, d);  chk("R11 reset ctrl", d, 0);

    // geometry: h 2/2/4/1, v 1/1/2/1 (stored minus one)
    wr(4, 1); wr(5, 1); wr(6, 3); wr(7, 0);
    wr(8, 0); wr(9, 0); wr(10, 1); wr(11, 0);
    wr(3, 4'b0111); wr(1, 1);
    rd(6, d);  chk("R1 R11 h active readback", d, 3);
    rd(3, d);  chk("R5 R11 polarity readback", d, 7);
    chk("R5 data polarity", dinv, 1'b0);

    // R10: active width changed mid-frame, applies to frame 2 only
    push_frame(2, 2, 4, 1, 1, 1, 2, 1, 4'b0111, 1'b0);
    push_frame(2, 2, 3, 1, 1, 1, 2, 1, 4'b0111, 1'b1);
    start_mon();
    repeat (10) @(negedge clk);
    wr(6, 2);
    wait (mon_on == 1'b0);

    wr(0, 0);
    chk("R6 stopped strobes", {hsync, vsync, de, x, y}, 27'd0);
    chk("R7 status sticky", irq, 1'b1);
    wr(1, 0); chk("R8 masked", irq, 1'b0);
    wr(1, 1); chk("R8 unmasked", irq, 1'b1);
    wr(2, 0); chk("R9 write zero keeps", irq, 1'b1);
    wr(2, 1); chk("R9 clear", irq, 1'b0);

    // R9 collision: clear issued in the first frame cycle
    @(negedge clk);
    wr_en = 1'b1; addr = 0; wdata = 1;
    @(negedge clk);
    addr = 2; wdata = 1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 set wins over clear", irq, 1'b1);
    wr(2, 1); chk("R9 clear while running", irq, 1'b0);
    wr(0, 0);

    // R5/R6: inverted levels, restart from zero mid-frame
    wr(3, 4'b1000);
    chk("R5 data polarity set", dinv, 1'b1);
    chk("R6 R5 stopped active-low idle", {hsync, vsync, de}, 3'b111);
    push_frame(2, 2, 3, 1, 1, 1, 2, 1, 4'b1000, 1'b0);
    start_mon();
    wait (mon_on == 1'b0);
    rd(2, d); chk("R11 R7 status readback", d, 1);
    wr(0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule